// File: doc/BRIEF.md
# Redirection-Entry Interrupt Delivery Engine

This block sits between a set of 24 interrupt input pins and a memory-write message path. Interrupt sources report events as an indexed request (pin number plus level). The block keeps one pending bit per pin. It reads each pin's 64-bit redirection entry from a table owned elsewhere. It turns pending pins that are allowed to deliver into address/data write messages, handing out one message at a time over a valid/ready handshake.

Edge-triggered and level-triggered pins behave differently. An edge pin is consumed when its message is accepted. A level pin stays pending for as long as its source holds it. A level pin blocks further deliveries through the remote-IRR status bit of its entry. The block sets that bit by reporting a pulse to the table owner, and only the table owner clears it again. When several pins can deliver at once, the lowest pin index goes first. Pending state is re-evaluated every cycle, so any change in the pending bits or in the table takes effect on the next pick.

Top module: `irq_route_engine`

## Requirements
- R1: After reset, `msg_valid` and `rirr_set_valid` are low and no pin is pending, so no message appears until a new request arrives.
- R2: A request on index 0 acts on pin 2. Indices 1 to 23 map to the pin with the same number. A request on index 24 or higher has no effect.
- R3: A request with level 1 on an edge pin (entry bit 15 = 0) whose mask bit (entry bit 16) is set is dropped: clearing the mask later sends nothing. A request with level 0 on an edge pin has no effect.
- R4: A pending edge pin whose mask bit is clear sends one message, and its pending bit clears when that message is accepted. A rising request for the same pin in the accepting cycle makes the pin pending again, and it sends a second message.
- R5: On a level pin (entry bit 15 = 1), a level-1 request sets the pending bit and a level-0 request clears it, whatever the mask bit.
- R6: A pending, unmasked level pin whose remote-IRR bit (entry bit 14) is clear sends a message. On acceptance the block pulses `rirr_set_valid` with `rirr_set_pin`, and the pin stays pending. While bit 14 is set the pin sends nothing. Once the table owner clears bit 14, the pin sends again if it is still pending.
- R7: A pending pin whose mask bit is set sends nothing and keeps its pending state. It delivers once the mask bit is cleared.
- R8: The message address is 0xFEE00000 OR the destination field (entry bits 63:48) shifted to bit 4, OR the destination-mode bit (entry bit 11) placed at bit 2.
- R9: The message data holds the vector (entry bits 7:0) in bits 7:0, the delivery mode (entry bits 10:8) in bits 10:8, and the trigger bit (entry bit 15) in bit 15. All other data bits are zero.
- R10: When several pins can deliver, messages go out in ascending pin order, one per accepted handshake.
- R11: Once `msg_valid` is high it stays high, with `msg_addr` and `msg_data` unchanged, until `msg_ready` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A pin event is presented this cycle |
| req_pin | input | 5 | Requested input index (0 redirects to pin 2) |
| req_level | input | 1 | Level carried by the event |
| tbl_flat | input | 1536 | Redirection entries, pin i in bits [64*i+63 : 64*i] |
| msg_valid | output | 1 | Outgoing message is valid |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data |
| msg_ready | input | 1 | Consumer accepts the message |
| rirr_set_valid | output | 1 | Pulse: set remote-IRR of `rirr_set_pin` |
| rirr_set_pin | output | 5 | Pin whose remote-IRR must be set |

## Verification
The hardest state to reach is a rising request on an edge pin in the very cycle its previous message is accepted. Here the clear from acceptance and the new set collide on the same pending bit. The bench reaches it by holding `msg_ready` low until the message for that pin is parked at the output. It then raises `msg_ready` and presents the new request in the same cycle, and expects exactly two deliveries. The level-pin cycle needs the bench to act as the table owner: it writes remote-IRR back from the set pulses, shows that a held level pin goes quiet, and then clears the bit by hand to see the same pin deliver again.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam int ENTRY_W      = 64;

  // redirection entry layout
  localparam int VEC_LSB      = 0;
  localparam int VEC_W        = 8;
  localparam int DLV_LSB      = 8;
  localparam int DLV_W        = 3;
  localparam int DMODE_BIT    = 11;
  localparam int RIRR_BIT     = 14;
  localparam int TRIG_BIT     = 15;
  localparam int MASK_BIT     = 16;
  localparam int DEST_LSB     = 48;
  localparam int DEST_W       = 16;

  // message layout
  localparam logic [31:0] MSG_ADDR_BASE = 32'hFEE0_0000;
  localparam int ADDR_DEST_SH  = 4;
  localparam int ADDR_DMODE_SH = 2;
  localparam int DATA_VEC_SH   = 0;
  localparam int DATA_DLV_SH   = 8;
  localparam int DATA_TRIG_SH  = 15;

  function automatic logic [31:0] build_addr(input logic [ENTRY_W-1:0] ent);
    logic [31:0] a;
    a = MSG_ADDR_BASE;
    a = a | (32'(ent[DEST_LSB +: DEST_W]) << ADDR_DEST_SH);
    a = a | (32'(ent[DMODE_BIT]) << ADDR_DMODE_SH);
    return a;
  endfunction

  function automatic logic [31:0] build_data(input logic [ENTRY_W-1:0] ent);
    logic [31:0] d;
    d = 32'(ent[VEC_LSB +: VEC_W]) << DATA_VEC_SH;
    d = d | (32'(ent[DLV_LSB +: DLV_W]) << DATA_DLV_SH);
    d = d | (32'(ent[TRIG_BIT]) << DATA_TRIG_SH);
    return d;
  endfunction

endpackage

// File: rtl/irq_pin_latch.sv
module irq_pin_latch #(
  parameter int NPINS = 24,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [IDX_W-1:0] req_pin,
  input  logic             req_level,
  input  logic [NPINS-1:0] trig_v,
  input  logic [NPINS-1:0] mask_v,
  input  logic             retire_valid,
  input  logic [IDX_W-1:0] retire_pin,
  input  logic             retire_edge,
  output logic [NPINS-1:0] pend,
  output logic [NPINS-1:0] set_v,
  output logic [NPINS-1:0] drop_v
);

  localparam logic [IDX_W-1:0] REDIR_FROM = '0;
  localparam logic [IDX_W-1:0] REDIR_TO   = IDX_W'(2);

  logic [IDX_W-1:0] tgt;
  logic             in_range;

  assign tgt      = (req_pin == REDIR_FROM) ? REDIR_TO : req_pin;
  assign in_range = ({1'b0, tgt} < (IDX_W+1)'(NPINS));

  for (genvar gi = 0; gi < NPINS; gi++) begin : g_pin
    logic hit, clr;
    assign hit        = req_valid && in_range && (tgt == IDX_W'(gi));
    assign set_v[gi]  = hit && req_level && (trig_v[gi] || !mask_v[gi]);
    assign drop_v[gi] = hit && !req_level && trig_v[gi];
    assign clr        = retire_valid && retire_edge && (retire_pin == IDX_W'(gi));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            pend[gi] <= 1'b0;
      else if (set_v[gi])    pend[gi] <= 1'b1;
      else if (drop_v[gi] || clr) pend[gi] <= 1'b0;
    end
  end

  assert_far_pin_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !in_range && !retire_valid) |=> $stable(pend));

  assert_masked_edge_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && in_range && !trig_v[tgt] && mask_v[tgt] && !pend[tgt])
    |=> !pend[$past(tgt)]);

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int NPINS = 24,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] elig,
  output logic             pick_valid,
  output logic [IDX_W-1:0] pick_idx
);

  logic [NPINS:0]   seen;
  logic [NPINS-1:0] first;

  assign seen[0] = 1'b0;
  for (genvar gi = 0; gi < NPINS; gi++) begin : g_chain
    assign seen[gi+1] = seen[gi] | elig[gi];
    assign first[gi]  = elig[gi] & ~seen[gi];
  end

  assign pick_valid = seen[NPINS];

  always_comb begin
    pick_idx = '0;
    for (int k = 0; k < NPINS; k++) begin
      if (first[k]) pick_idx = pick_idx | IDX_W'(k);
    end
  end

  assert_single_winner_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(first));

  assert_lowest_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pick_valid |-> (elig[pick_idx] &&
      ((elig & ((NPINS'(1) << pick_idx) - NPINS'(1))) == '0)));

endmodule

// File: rtl/irq_msg_out.sv
module irq_msg_out #(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_valid,
  input  logic [IDX_W-1:0] load_pin,
  input  logic             load_level,
  input  logic [31:0]      load_addr,
  input  logic [31:0]      load_data,
  input  logic             msg_ready,
  output logic             msg_valid,
  output logic [31:0]      msg_addr,
  output logic [31:0]      msg_data,
  output logic [IDX_W-1:0] held_pin,
  output logic             held_level,
  output logic             take,
  output logic             accept
);

  assign take   = !msg_valid || msg_ready;
  assign accept = msg_valid && msg_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid  <= 1'b0;
      msg_addr   <= '0;
      msg_data   <= '0;
      held_pin   <= '0;
      held_level <= 1'b0;
    end else if (take) begin
      msg_valid <= load_valid;
      if (load_valid) begin
        msg_addr   <= load_addr;
        msg_data   <= load_data;
        held_pin   <= load_pin;
        held_level <= load_level;
      end
    end
  end

  assert_hold_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

endmodule

// File: rtl/irq_route_engine.sv
module irq_route_engine
  import irq_route_pkg::*;
#(
  parameter int NPINS = 24,
  localparam int IDX_W = $clog2(NPINS),
  localparam int TBL_W = NPINS * ENTRY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [IDX_W-1:0] req_pin,
  input  logic             req_level,
  input  logic [TBL_W-1:0] tbl_flat,
  output logic             msg_valid,
  output logic [31:0]      msg_addr,
  output logic [31:0]      msg_data,
  input  logic             msg_ready,
  output logic             rirr_set_valid,
  output logic [IDX_W-1:0] rirr_set_pin
);

  logic [NPINS-1:0][ENTRY_W-1:0] ent;
  logic [NPINS-1:0] trig_v, mask_v, rirr_v;
  logic [NPINS-1:0] pend, set_v, drop_v, retire_oh, elig;
  logic             pick_valid;
  logic [IDX_W-1:0] pick_idx;
  logic [ENTRY_W-1:0] ent_sel;
  logic [IDX_W-1:0] held_pin;
  logic             held_level, take, accept;

  assign ent = tbl_flat;

  for (genvar gi = 0; gi < NPINS; gi++) begin : g_fields
    assign trig_v[gi]    = ent[gi][TRIG_BIT];
    assign mask_v[gi]    = ent[gi][MASK_BIT];
    assign rirr_v[gi]    = ent[gi][RIRR_BIT];
    assign retire_oh[gi] = accept && (held_pin == IDX_W'(gi));
  end

  // deliverable: pending, unmasked, and for level pins no outstanding remote-IRR
  assign elig = pend & ~mask_v & (~trig_v | ~rirr_v) & ~retire_oh;

  irq_pin_latch #(.NPINS(NPINS), .IDX_W(IDX_W)) latch_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_pin(req_pin), .req_level(req_level),
    .trig_v(trig_v), .mask_v(mask_v),
    .retire_valid(accept), .retire_pin(held_pin), .retire_edge(!held_level),
    .pend(pend), .set_v(set_v), .drop_v(drop_v)
  );

  irq_pick #(.NPINS(NPINS), .IDX_W(IDX_W)) pick_i (
    .clk(clk), .rst_n(rst_n), .elig(elig),
    .pick_valid(pick_valid), .pick_idx(pick_idx)
  );

  assign ent_sel = ({1'b0, pick_idx} < (IDX_W+1)'(NPINS)) ? ent[pick_idx] : '0;

  irq_msg_out #(.IDX_W(IDX_W)) out_i (
    .clk(clk), .rst_n(rst_n),
    .load_valid(pick_valid), .load_pin(pick_idx), .load_level(ent_sel[TRIG_BIT]),
    .load_addr(build_addr(ent_sel)), .load_data(build_data(ent_sel)),
    .msg_ready(msg_ready),
    .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data),
    .held_pin(held_pin), .held_level(held_level), .take(take), .accept(accept)
  );

  assign rirr_set_valid = accept && held_level;
  assign rirr_set_pin   = held_pin;

  assert_edge_retire_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !held_level && !set_v[held_pin]) |=> !pend[$past(held_pin)]);

  assert_level_stays_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rirr_set_valid && !drop_v[rirr_set_pin]) |=> pend[$past(rirr_set_pin)]);

  assert_load_only_when_free_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !take) |=> msg_valid);

endmodule

// File: tb/irq_route_engine_tb.sv
`timescale 1ns/1ps
module irq_route_engine_tb_top;

  localparam int NP = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [4:0] req_pin = '0;
  logic req_level = 1'b0;
  logic msg_ready = 1'b1;
  logic [63:0] tbl [NP];
  logic [NP*64-1:0] tbl_flat;
  logic msg_valid, rirr_set_valid;
  logic [31:0] msg_addr, msg_data;
  logic [4:0] rirr_set_pin;

  int n_chk = 0, n_fail = 0, n_msg = 0, n_rirr = 0;
  logic [31:0] log_addr [64];
  logic [31:0] log_data [64];
  logic [4:0] last_rirr_pin = '0;
  bit done = 0;

  always #2 clk = ~clk;

  always_comb for (int i = 0; i < NP; i++) tbl_flat[i*64 +: 64] = tbl[i];

  irq_route_engine dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pin(req_pin),
    .req_level(req_level), .tbl_flat(tbl_flat), .msg_valid(msg_valid),
    .msg_addr(msg_addr), .msg_data(msg_data), .msg_ready(msg_ready),
    .rirr_set_valid(rirr_set_valid), .rirr_set_pin(rirr_set_pin)
  );

  function automatic logic [63:0] mk(input logic [7:0] vec, input logic [2:0] dm,
      input bit dmode, input bit trig, input bit mask, input logic [15:0] dest);
    logic [63:0] e = '0;
    e[7:0] = vec; e[10:8] = dm; e[11] = dmode; e[15] = trig; e[16] = mask;
    e[63:48] = dest;
    return e;
  endfunction

  function automatic logic [31:0] x_addr(input logic [15:0] dest, input bit dmode);
    return 32'hFEE00000 + 32'(dest) * 16 + (dmode ? 32'd4 : 32'd0);
  endfunction

  function automatic logic [31:0] x_data(input logic [7:0] vec, input logic [2:0] dm, input bit trig);
    return 32'(vec) + 32'(dm) * 256 + (trig ? 32'd32768 : 32'd0);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock: called and returns at a falling edge
  task automatic cyc();
    bit acc, fire;
    logic [4:0] fp;
    logic [31:0] a, d;
    acc = msg_valid && msg_ready; a = msg_addr; d = msg_data;
    fire = rirr_set_valid; fp = rirr_set_pin;
    @(posedge clk);
    @(negedge clk);
    if (acc) begin
      if (n_msg < 64) begin log_addr[n_msg] = a; log_data[n_msg] = d; end
      n_msg++;
    end
    if (fire) begin
      tbl[fp][14] = 1'b1; n_rirr++; last_rirr_pin = fp;
    end
  endtask

  task automatic run(input int n);
    repeat (n) cyc();
  endtask

  task automatic pulse_req(input logic [4:0] p, input bit lvl);
    req_valid = 1'b1; req_pin = p; req_level = lvl;
    cyc();
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk(msg_valid == 1'b0, "R1 msg_valid in reset", 32'(msg_valid), 0);
    chk(rirr_set_valid == 1'b0, "R1 rirr_set in reset", 32'(rirr_set_valid), 0);
    rst_n = 1'b1;
    run(6);
    chk(n_msg == 0, "R1 no message after reset", n_msg, 0);
  endtask

  task automatic t_edge_basic();
    int b = n_msg, r = n_rirr;
    tbl[5] = mk(8'h41, 3'b100, 1, 0, 0, 16'h1234);
    pulse_req(5'd5, 1);
    run(8);
    chk(n_msg == b + 1, "R4 one edge message", n_msg - b, 1);
    chk(log_addr[b] == x_addr(16'h1234, 1), "R8 address", log_addr[b], x_addr(16'h1234, 1));
    chk(log_data[b] == x_data(8'h41, 3'b100, 0), "R9 edge data", log_data[b], x_data(8'h41, 3'b100, 0));
    chk(n_rirr == r, "R4 edge sets no remote-IRR", n_rirr - r, 0);
  endtask

  task automatic t_remap();
    int b = n_msg;
    tbl[0] = mk(8'h10, 3'b000, 0, 0, 0, 16'h0001);
    tbl[2] = mk(8'h22, 3'b000, 0, 0, 0, 16'h0002);
    pulse_req(5'd0, 1);
    run(6);
    chk(n_msg == b + 1, "R2 index 0 delivers once", n_msg - b, 1);
    chk(log_data[b] == 32'h22, "R2 index 0 lands on pin 2", log_data[b], 32'h22);
    b = n_msg;
    pulse_req(5'd24, 1);
    pulse_req(5'd31, 1);
    run(6);
    chk(n_msg == b, "R2 indices at or above 24 ignored", n_msg - b, 0);
  endtask

  task automatic t_masked_edge();
    int b = n_msg;
    tbl[7] = mk(8'h77, 3'b000, 0, 0, 1, 16'h0007);
    pulse_req(5'd7, 1);
    run(3);
    tbl[7][16] = 1'b0;
    run(6);
    chk(n_msg == b, "R3 masked edge request dropped", n_msg - b, 0);
    pulse_req(5'd7, 0);
    run(6);
    chk(n_msg == b, "R3 low level on edge pin no effect", n_msg - b, 0);
  endtask

  task automatic t_level_cycle();
    int b = n_msg, r = n_rirr;
    tbl[9] = mk(8'h39, 3'b001, 0, 1, 1, 16'h00AB);
    pulse_req(5'd9, 1);
    run(6);
    chk(n_msg == b, "R7 masked level pin sends nothing", n_msg - b, 0);
    tbl[9][16] = 1'b0;
    run(6);
    chk(n_msg == b + 1, "R7 unmask delivers pending pin", n_msg - b, 1);
    chk(log_data[b] == x_data(8'h39, 3'b001, 1), "R9 level data", log_data[b], x_data(8'h39, 3'b001, 1));
    chk(log_addr[b] == x_addr(16'h00AB, 0), "R8 address level", log_addr[b], x_addr(16'h00AB, 0));
    chk(n_rirr == r + 1 && last_rirr_pin == 5'd9, "R6 remote-IRR set reported", 32'(last_rirr_pin), 9);
    run(8);
    chk(n_msg == b + 1, "R6 no delivery while remote-IRR set", n_msg - b, 1);
    tbl[9][14] = 1'b0;
    run(6);
    chk(n_msg == b + 2, "R6 redelivery after remote-IRR cleared", n_msg - b, 2);
    pulse_req(5'd9, 0);
    tbl[9][14] = 1'b0;
    run(6);
    chk(n_msg == b + 2, "R5 low level clears pending", n_msg - b, 2);
    tbl[9][16] = 1'b1;
  endtask

  task automatic t_level_drop_masked();
    int b = n_msg;
    tbl[10] = mk(8'hA0, 3'b000, 0, 1, 1, 16'h0000);
    pulse_req(5'd10, 1);
    pulse_req(5'd10, 0);
    tbl[10][16] = 1'b0;
    run(6);
    chk(n_msg == b, "R5 masked level set then cleared", n_msg - b, 0);
    tbl[10][16] = 1'b1;
  endtask

  task automatic t_order();
    int b = n_msg;
    logic [31:0] held;
    tbl[4]  = mk(8'h44, 3'b000, 0, 0, 0, 16'h0000);
    tbl[12] = mk(8'h4C, 3'b000, 0, 0, 0, 16'h0000);
    tbl[20] = mk(8'h54, 3'b000, 0, 0, 0, 16'h0000);
    msg_ready = 1'b0;
    pulse_req(5'd12, 1);
    pulse_req(5'd20, 1);
    pulse_req(5'd4, 1);
    run(1);
    held = msg_data;
    chk(msg_valid && held == 32'h4C, "R11 first message parked", held, 32'h4C);
    run(3);
    chk(msg_valid && msg_data == held, "R11 held stable without ready", msg_data, held);
    msg_ready = 1'b1;
    run(8);
    chk(n_msg == b + 3, "R10 three messages", n_msg - b, 3);
    chk(log_data[b+1] == 32'h44 && log_data[b+2] == 32'h54, "R10 ascending order",
        {log_data[b+1][15:0], log_data[b+2][15:0]}, 32'h0044_0054);
  endtask

  task automatic t_edge_collide();
    int b = n_msg;
    tbl[6] = mk(8'h66, 3'b000, 0, 0, 0, 16'h0000);
    msg_ready = 1'b0;
    pulse_req(5'd6, 1);
    run(2);
    chk(msg_valid && msg_data == 32'h66, "R4 edge message parked", msg_data, 32'h66);
    msg_ready = 1'b1;
    pulse_req(5'd6, 1);
    run(8);
    chk(n_msg == b + 2, "R4 rise during accept repends", n_msg - b, 2);
  endtask

  initial begin
    for (int i = 0; i < NP; i++) tbl[i] = mk(8'h00, 3'b000, 0, 0, 1, 16'h0000);
    @(negedge clk);
    run(3);
    t_reset();
    t_edge_basic();
    t_remap();
    t_masked_edge();
    t_level_cycle();
    t_level_drop_masked();
    t_order();
    t_edge_collide();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule